// File: doc/BRIEF.md
# FM Synthesizer Two-Bank Host Register Port

This block is the host-side front end of a six-channel FM synthesizer. The host reaches it through one 8-bit write bus with a 2-bit port select. Port 0 is the address port of bank 0 and port 1 is its data port. Port 2 is the address port of bank 1 and port 3 is its data port. A byte written to an address port is held in that bank's address latch. Every later byte written to the same bank's data port goes to the register that the latch names. The latch keeps its value, so a run of data writes can go to one register without a new address.

Both banks decode the same per-channel register layout. The two low address bits pick a slot within a bank. Slots 0 to 2 of bank 0 are engine channels 0 to 2, and the same slots of bank 1 are channels 3 to 5. Each accepted per-channel write is passed to the engine as a one-cycle update event that carries the mapped channel. A few global registers are decoded only from bank 0: the key-on register, the DAC sample and the DAC enable. Their effects appear as output state. All stored bytes can be read back through a separate registered read port.

Top module: `fmh_host_port`

## Requirements
- R1: While `rst` is high and after it falls, both address latches read as 0x00, `key_ops` is 0, `dac_level` is 0, `dac_en` is 0 and `upd_valid` is 0.
- R2: A data-port write uses the last byte written to the address port of the same bank (port 0 for bank 0, port 2 for bank 1). The latch keeps its value across any number of data writes, and writes to the other bank never change it.
- R3: A per-channel register is an address in 0x30..0x9F, 0xA0..0xA7 or 0xB0..0xB7 whose low two bits are not 3. A data write to one stores the byte. Presenting `rd_bank`/`rd_addr` returns that byte on `rd_data` one clock later.
- R4: An accepted per-channel write raises `upd_valid` for exactly one cycle after the write edge. It also gives `upd_chan` = 3*bank + addr[1:0], `upd_reg` = the address with bits 1:0 cleared, and `upd_data` = the byte.
- R5: A data write to an address that is neither a per-channel register nor a global register of bank 0 stores nothing and raises no event. Such an address reads back as 0x00.
- R6: A bank-0 write to 0x28 sets the 4-bit operator mask `key_ops[4*ch+3:4*ch]` to data[7:4]. The channel code data[2:0] gives ch: codes 0..2 map to 0..2, codes 4..6 map to 3..5, and codes 3 and 7 change nothing.
- R7: A bank-0 write to 0x2A loads `dac_level` with the byte. A bank-0 write to 0x2B loads `dac_en` from data bit 7.
- R8: Writes to 0x20..0x2F through bank 1 are ignored: key, DAC and event outputs stay unchanged, and those bank-1 addresses read back as 0x00.
- R9: Any bank-0 write to 0x20..0x2F stores the byte, which reads back through bank 0.
- R10: With `wr_en` low the port and data inputs have no effect on any output or stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_port | input | 2 | 0/2 address port of bank 0/1, 1/3 data port of bank 0/1 |
| wr_data | input | 8 | Write byte |
| rd_bank | input | 1 | Read-back bank |
| rd_addr | input | 8 | Read-back register address |
| rd_data | output | 8 | Read-back byte, one cycle after the address; 0 for non-registers |
| key_ops | output | 24 | Per-channel operator key mask, 4 bits per channel |
| dac_level | output | 8 | DAC sample byte |
| dac_en | output | 1 | DAC enable |
| upd_valid | output | 1 | Per-channel update event |
| upd_chan | output | 3 | Mapped engine channel 0..5 |
| upd_reg | output | 8 | Register group address (slot bits cleared) |
| upd_data | output | 8 | Written byte |

## Verification
Random writes go to both banks with address and data ports interleaved, so a design that shares one latch between banks sends data to the wrong register. Address slot 3, the gaps at 0xA8..0xAF and above 0xB7, and bank-1 writes to 0x28, 0x2A and 0x2B are aimed at directly. A decoder that accepts any of them shows up as a spurious event, a moved key mask or a non-zero read-back. Key codes 3 and 7 and the bank-1 slots are checked against the 3*bank+slot mapping, which a design that drops the bank bit or treats code 4 as channel 4 would fail.

// File: rtl/fmh_pkg.sv
package fmh_pkg;
  localparam int BYTE_W  = 8;
  localparam int REG_AW  = 8;
  // Global register window 0x20..0x2F, bank 0 only
  localparam logic [3:0] GLOB_NIB  = 4'h2;
  localparam logic [3:0] KEY_LOW   = 4'h8;
  localparam logic [3:0] DACV_LOW  = 4'hA;
  localparam logic [3:0] DACC_LOW  = 4'hB;
  // Per-channel groups
  localparam logic [7:0] OPG_FIRST = 8'h30;
  localparam logic [7:0] OPG_LAST  = 8'h9F;
  localparam logic [4:0] FRQ_TOP5  = 5'b10100;  // 0xA0..0xA7
  localparam logic [4:0] ALG_TOP5  = 5'b10110;  // 0xB0..0xB7

  function automatic logic chan_group_hit(input logic [7:0] a);
    return (a >= OPG_FIRST && a <= OPG_LAST) ||
           (a[7:3] == FRQ_TOP5) || (a[7:3] == ALG_TOP5);
  endfunction
endpackage

// File: rtl/fmh_addr_latch.sv
module fmh_addr_latch #(
  parameter int ADDR_W = 8,
  parameter int BANKS  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_port,
  input  logic [ADDR_W-1:0]       wr_byte,
  output logic [BANKS*ADDR_W-1:0] addr_q
);
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = wr_en && !wr_port[0] && (int'(wr_port[1]) == b);

    always_ff @(posedge clk) begin
      if (rst)      addr_q[b*ADDR_W +: ADDR_W] <= '0;
      else if (hit) addr_q[b*ADDR_W +: ADDR_W] <= wr_byte;
    end

    // R2: a bank latch moves only after an address-port write to that bank
    a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
      !$stable(addr_q[b*ADDR_W +: ADDR_W]) |->
        $past(wr_en && !wr_port[0] && (int'(wr_port[1]) == b)));
  end
endmodule

// File: rtl/fmh_decode.sv
module fmh_decode #(
  parameter int ADDR_W      = 8,
  parameter int CH_PER_BANK = 3,
  parameter int CH_W        = 3
) (
  input  logic              bank,
  input  logic [ADDR_W-1:0] addr,
  output logic              is_chan,
  output logic              is_glob,
  output logic [CH_W-1:0]   chan
);
  import fmh_pkg::*;
  logic [1:0] slot;
  assign slot    = addr[1:0];
  assign is_chan = chan_group_hit(addr[7:0]) && (int'(slot) < CH_PER_BANK);
  assign is_glob = !bank && (addr[7:4] == GLOB_NIB);
  assign chan    = CH_W'(bank ? CH_PER_BANK : 0) + CH_W'(slot);
endmodule

// File: rtl/fmh_regfile.sv
module fmh_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              ok_q;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rd_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) ok_q <= 1'b0;
    else     ok_q <= rvalid;
  end

  assign rdata = ok_q ? rd_q : '0;
endmodule

// File: rtl/fmh_host_port.sv
module fmh_host_port #(
  parameter int DATA_W      = fmh_pkg::BYTE_W,
  parameter int ADDR_W      = fmh_pkg::REG_AW,
  parameter int CH_PER_BANK = 3,
  parameter int OP_N        = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [1:0]                    wr_port,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          rd_bank,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]             rd_data,
  output logic [2*CH_PER_BANK*OP_N-1:0] key_ops,
  output logic [DATA_W-1:0]             dac_level,
  output logic                          dac_en,
  output logic                          upd_valid,
  output logic [$clog2(2*CH_PER_BANK)-1:0] upd_chan,
  output logic [ADDR_W-1:0]             upd_reg,
  output logic [DATA_W-1:0]             upd_data
);
  import fmh_pkg::*;
  localparam int NCH   = 2 * CH_PER_BANK;
  localparam int CH_W  = $clog2(NCH);
  localparam int IDX_W = ADDR_W + 1;

  logic [2*ADDR_W-1:0] latch_q;
  logic                wr_bank;
  logic [ADDR_W-1:0]   cur_addr;
  logic                data_wr;
  logic                w_chan, w_glob, r_chan, r_glob;
  logic [CH_W-1:0]     w_ch, r_ch_unused;

  assign wr_bank  = wr_port[1];
  assign cur_addr = latch_q[wr_bank*ADDR_W +: ADDR_W];
  assign data_wr  = wr_en && wr_port[0];

  fmh_addr_latch #(.ADDR_W(ADDR_W), .BANKS(2)) u_latch (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port),
    .wr_byte(wr_data[ADDR_W-1:0]), .addr_q(latch_q));

  fmh_decode #(.ADDR_W(ADDR_W), .CH_PER_BANK(CH_PER_BANK), .CH_W(CH_W)) u_wdec (
    .bank(wr_bank), .addr(cur_addr), .is_chan(w_chan), .is_glob(w_glob), .chan(w_ch));

  fmh_decode #(.ADDR_W(ADDR_W), .CH_PER_BANK(CH_PER_BANK), .CH_W(CH_W)) u_rdec (
    .bank(rd_bank), .addr(rd_addr), .is_chan(r_chan), .is_glob(r_glob), .chan(r_ch_unused));

  fmh_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst),
    .we(data_wr && (w_chan || w_glob)), .widx({wr_bank, cur_addr}), .wdata(wr_data),
    .ridx({rd_bank, rd_addr}), .rvalid(r_chan || r_glob), .rdata(rd_data));

  // Key-on channel code: bit 2 selects the upper group
  logic [2:0]      kcode;
  logic            kcode_ok;
  logic [CH_W-1:0] kchan;
  assign kcode    = wr_data[2:0];
  assign kcode_ok = int'(kcode[1:0]) < CH_PER_BANK;
  assign kchan    = CH_W'(kcode[2] ? CH_PER_BANK : 0) + CH_W'(kcode[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      key_ops   <= '0;
      dac_level <= '0;
      dac_en    <= 1'b0;
    end else if (data_wr && w_glob) begin
      case (cur_addr[3:0])
        KEY_LOW: if (kcode_ok) begin
          for (int c = 0; c < NCH; c++)
            if (CH_W'(c) == kchan) key_ops[c*OP_N +: OP_N] <= wr_data[DATA_W-1 -: OP_N];
        end
        DACV_LOW: dac_level <= wr_data;
        DACC_LOW: dac_en    <= wr_data[DATA_W-1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_valid <= 1'b0;
      upd_chan  <= '0;
      upd_reg   <= '0;
      upd_data  <= '0;
    end else begin
      upd_valid <= data_wr && w_chan;
      if (data_wr && w_chan) begin
        upd_chan <= w_ch;
        upd_reg  <= {cur_addr[ADDR_W-1:2], 2'b00};
        upd_data <= wr_data;
      end
    end
  end

  // R4: events carry a channel in range and follow a data-port write
  a_r4_chan_range: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> (int'(upd_chan) < NCH));
  a_r4_event_src: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> $past(wr_en && wr_port[0]));
  // R6/R8: key state only moves after a bank-0 data write
  a_r6_key_src: assert property (@(posedge clk) disable iff (rst)
    !$stable(key_ops) |-> $past(wr_en && wr_port == 2'd1));
  // R7/R8: DAC state only moves after a bank-0 data write
  a_r7_dac_src: assert property (@(posedge clk) disable iff (rst)
    !$stable({dac_en, dac_level}) |-> $past(wr_en && wr_port == 2'd1));
  // R10: no strobe, no event
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    $past(!wr_en) |-> !upd_valid);
endmodule

// File: tb/test_fmh_host_port.sv
module test_fmh_host_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_port = '0;
  logic [7:0]  wr_data = '0;
  logic        rd_bank = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic [23:0] key_ops;
  logic [7:0]  dac_level;
  logic        dac_en;
  logic        upd_valid;
  logic [2:0]  upd_chan;
  logic [7:0]  upd_reg;
  logic [7:0]  upd_data;

  fmh_host_port i_fmh_host_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_addr(rd_addr), .rd_data(rd_data), .key_ops(key_ops),
    .dac_level(dac_level), .dac_en(dac_en), .upd_valid(upd_valid),
    .upd_chan(upd_chan), .upd_reg(upd_reg), .upd_data(upd_data));

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // model state
  logic [7:0]  m_latch [2];
  logic [7:0]  m_mem   [512];
  bit          m_set   [512];
  logic [23:0] m_key;
  logic [7:0]  m_dac;
  logic        m_den;

  function automatic bit chan_ok(input logic [7:0] a);
    return (a[1:0] != 2'd3) &&
      ((a >= 8'h30 && a <= 8'h9F) || (a >= 8'hA0 && a <= 8'hA7) || (a >= 8'hB0 && a <= 8'hB7));
  endfunction

  function automatic bit glob_ok(input logic b, input logic [7:0] a);
    return !b && (a[7:4] == 4'h2);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with outputs settled
  task automatic wr(input logic [1:0] p, input logic [7:0] d);
    logic b;
    logic [7:0] a;
    bit ev;
    logic [2:0] kc;
    b = p[1];
    wr_port = p; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    ev = 0;
    if (!p[0]) begin
      m_latch[b] = d;
    end else begin
      a = m_latch[b];
      if (chan_ok(a)) begin
        ev = 1;
        m_mem[{b, a}] = d; m_set[{b, a}] = 1;
        chk("R4 chan", 32'(upd_chan), 32'(3 * int'(b) + int'(a[1:0])));
        chk("R4 reg",  32'(upd_reg),  32'({a[7:2], 2'b00}));
        chk("R4 data", 32'(upd_data), 32'(d));
      end else if (glob_ok(b, a)) begin
        m_mem[{b, a}] = d; m_set[{b, a}] = 1;
        kc = d[2:0];
        if (a == 8'h28 && kc[1:0] != 2'd3)
          m_key[(3 * int'(kc[2]) + int'(kc[1:0])) * 4 +: 4] = d[7:4];
        if (a == 8'h2A) m_dac = d;
        if (a == 8'h2B) m_den = d[7];
      end
    end
    chk("R4/R5 upd_valid", 32'(upd_valid), 32'(ev));
    chk("R6/R8 key_ops", 32'(key_ops), 32'(m_key));
    chk("R7/R8 dac", 32'({dac_en, dac_level}), 32'({m_den, m_dac}));
  endtask

  task automatic rd(input logic b, input logic [7:0] a, input string tag);
    rd_bank = b; rd_addr = a;
    @(negedge clk);
    if (chan_ok(a) || glob_ok(b, a)) begin
      if (m_set[{b, a}]) chk(tag, 32'(rd_data), 32'(m_mem[{b, a}]));
    end else begin
      chk(tag, 32'(rd_data), 32'h0);
    end
  endtask

  task automatic idle_junk();
    wr_port = 2'($urandom); wr_data = 8'($urandom); wr_en = 1'b0;
    @(negedge clk);
    chk("R10 idle upd_valid", 32'(upd_valid), 32'h0);
    chk("R10 idle key", 32'(key_ops), 32'(m_key));
    chk("R10 idle dac", 32'({dac_en, dac_level}), 32'({m_den, m_dac}));
  endtask

  function automatic logic [7:0] pick_addr();
    case ($urandom % 5)
      0: return 8'($urandom);
      1: return 8'h20 + 8'($urandom % 16);
      2: return 8'h30 + 8'($urandom % 8'h70);
      3: return 8'hA0 + 8'($urandom % 8'h18);
      default: begin
        case ($urandom % 3)
          0: return 8'h28;
          1: return 8'h2A;
          default: return 8'h2B;
        endcase
      end
    endcase
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2e3f41));
    m_latch[0] = 8'h00; m_latch[1] = 8'h00;
    m_key = '0; m_dac = '0; m_den = 1'b0;
    for (int i = 0; i < 512; i++) begin m_mem[i] = '0; m_set[i] = 0; end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 key_ops", 32'(key_ops), 32'h0);
    chk("R1 dac_level", 32'(dac_level), 32'h0);
    chk("R1 dac_en", 32'(dac_en), 32'h0);
    chk("R1 upd_valid", 32'(upd_valid), 32'h0);
    // R1: latch 0x00 is not a register, so data writes do nothing
    wr(2'd1, 8'h5A);
    wr(2'd3, 8'hA5);
    rd(1'b0, 8'h00, "R1/R5 read 0x00");

    // R2: retention over several data writes, and bank independence
    wr(2'd0, 8'h41);
    wr(2'd2, 8'h42);
    wr(2'd1, 8'h11);
    wr(2'd1, 8'h22);
    wr(2'd3, 8'h33);
    wr(2'd1, 8'h44);
    rd(1'b0, 8'h41, "R2 bank0 retained");
    rd(1'b1, 8'h42, "R2 bank1 own latch");
    rd(1'b0, 8'h42, "R2 bank0 not written at 0x42");

    // R3/R4: bank-1 slot mapping to channels 3..5
    for (int s = 0; s < 3; s++) begin
      wr(2'd2, 8'hA4 + 8'(s));
      wr(2'd3, 8'h60 + 8'(s));
      rd(1'b1, 8'hA4 + 8'(s), "R3 bank1 readback");
    end

    // R5: slot 3, gap and out-of-map addresses
    wr(2'd0, 8'h33); wr(2'd1, 8'hFF); rd(1'b0, 8'h33, "R5 slot3");
    wr(2'd2, 8'hA9); wr(2'd3, 8'hFF); rd(1'b1, 8'hA9, "R5 gap 0xA9");
    wr(2'd0, 8'hB8); wr(2'd1, 8'hFF); rd(1'b0, 8'hB8, "R5 above 0xB7");
    wr(2'd0, 8'h1F); wr(2'd1, 8'hFF); rd(1'b0, 8'h1F, "R5 below globals");

    // R6: key codes including ignored 3 and 7
    wr(2'd0, 8'h28);
    wr(2'd1, 8'hF0); wr(2'd1, 8'hA6); wr(2'd1, 8'h53);
    wr(2'd1, 8'hC7); wr(2'd1, 8'h94); wr(2'd1, 8'h32);
    chk("R6 key after codes", 32'(key_ops), 32'(m_key));

    // R7: DAC regs
    wr(2'd0, 8'h2A); wr(2'd1, 8'h9C);
    wr(2'd0, 8'h2B); wr(2'd1, 8'h80); wr(2'd1, 8'h7F);
    rd(1'b0, 8'h2B, "R9 global readback");

    // R8: bank-1 globals ignored
    wr(2'd2, 8'h28); wr(2'd3, 8'hF1);
    wr(2'd2, 8'h2A); wr(2'd3, 8'h11);
    wr(2'd2, 8'h2B); wr(2'd3, 8'h80);
    rd(1'b1, 8'h2B, "R8 bank1 global reads zero");

    idle_junk();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic b;
      b = 1'($urandom);
      if ($urandom % 3 == 0) wr({b, 1'b0}, pick_addr());
      else                   wr({b, 1'b1}, 8'($urandom));
      if (n % 3 == 0) rd(1'($urandom), pick_addr(), "R3/R5/R8/R9 random read");
      if (n % 17 == 0) idle_junk();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule